// File: doc/BRIEF.md
# Two-Beat Double-Data-Rate SRAM Port

This block is a synthesizable model of a synchronous SRAM port that moves data on both clock edges. Each access is a burst of exactly two words. A command is taken on a rising edge of the input clock K while the active-low load strobe is low. The same edge samples the direction select and the address. Write beats come in on the next rising edge of K and then on the following rising edge of the inverted clock K#. Each beat carries its own active-low lane selects.

Read beats leave the block on the rising edges of an output clock pair (C, C#). When `single_clk` is high, the input pair takes over that role. Beat 0 appears one and a half K cycles after the command edge and beat 1 half a cycle later. The data bus is modelled as a separate input, a separate output and an output enable. The enable is high only while a read beat is on the bus. An echo clock pair copies whichever output clock pair is selected.

The command pipeline is a K-domain state machine with states `CMD_IDLE`, `CMD_READ` and `CMD_WRITE` in two stages. A command moves from the capture stage to the issue stage on the next K edge. Leaving `CMD_IDLE` happens only on a loaded edge. The read output sequencer has a lead register clocked on the falling output phase and a trail register clocked on the rising output phase. Each takes the states `OS_QUIET`, `OS_LEAD` and `OS_TRAIL`. The transition `OS_QUIET -> OS_LEAD` fires on an issued read. `OS_LEAD` then forces `OS_TRAIL` on the next rising output edge. Both return to `OS_QUIET` when no read is pending.

Top module: `ddrb_sram_port`

## Requirements
- R1: With `load_n` high at a rising K edge, no transaction starts: the array is not written and `q_oe` stays low.
- R2: With `load_n` low at a rising K edge, `rd_wn` high selects a read and `rd_wn` low selects a write.
- R3: A read drives exactly two beats: `q_oe` is high for two consecutive half cycles and low afterwards.
- R4: With START_ZERO=0 the burst starts at word `addr[0]`: beat 0 goes to `{addr[ADDR_W-1:1], addr[0]}` and beat 1 goes to `{addr[ADDR_W-1:1], ~addr[0]}`. With START_ZERO=1, `addr[0]` has no effect and beat 0 always uses word bit 0 = 0.
- R5: Write beat 0 is sampled on the rising K edge one cycle after the command. Write beat 1 is sampled on the rising K# edge that follows it.
- R6: `bw_n[i]` is active low and sampled with its beat. It guards bits `[9i+8:9i]` (LANE_W=9). A lane whose select is high keeps its stored value.
- R7: Read beat 0 is on `q_out` from the rising edge of the selected negative output clock 1.5 K cycles after the command. Beat 1 follows from the next rising edge of the positive output clock.
- R8: With `single_clk` high, read beats are timed from K/K# and C/C# are ignored. With `single_clk` low, they are timed from C/C#.
- R9: `q_oe` is low during reset and whenever no read beat is being driven.
- R10: `echo_p`/`echo_n` follow C/C# when `single_clk` is low and K/K# when it is high.
- R11: Commands may be issued on consecutive K edges. A read issued one cycle after a write to the same address returns the newly written data, merged by lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Input clock K; commands and write beat 0 on its rising edge |
| clk_kn | input | 1 | Inverted input clock K#; write beat 1 on its rising edge |
| clk_c | input | 1 | Positive output clock C |
| clk_cn | input | 1 | Negative output clock C# |
| single_clk | input | 1 | High: time read data and echo from K/K# |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| load_n | input | 1 | Active-low command strobe |
| rd_wn | input | 1 | High read, low write |
| addr | input | ADDR_W | Word address; bit 0 seeds the burst unless START_ZERO=1 |
| bw_n | input | LANES | Active-low lane write selects, one per beat |
| d_in | input | LANES*LANE_W | Write data beats |
| q_out | output | LANES*LANE_W | Read data beats |
| q_oe | output | 1 | High while a read beat is driven on the bus |
| echo_p | output | 1 | Echo of the selected positive output clock |
| echo_n | output | 1 | Echo of the selected negative output clock |

## Verification
The bench builds two instances that share every input. Both use 16 words of two 9-bit lanes. One has START_ZERO=0 and the other START_ZERO=1, so odd start addresses give opposite beat orders on the two outputs, side by side. The output clock pair is delayed 1 ns behind K. This means a probe just after a K# edge tells the two timing modes apart, and so does an echo probe just after a K edge. The C pair is stopped during single-clock runs to show that it is ignored.

// File: rtl/ddrb_pkg.sv
`timescale 1ns/1ps
package ddrb_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        OS_QUIET = 2'd0,
        OS_LEAD  = 2'd1,
        OS_TRAIL = 2'd2
    } ostate_e;
endpackage

// File: rtl/ddrb_cmd_decode.sv
`timescale 1ns/1ps
module ddrb_cmd_decode
    import ddrb_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int LANE_W     = 9,
    parameter int LANES      = 2,
    parameter int START_ZERO = 0,
    localparam int DATA_W    = LANE_W * LANES,
    localparam int PAIR_W    = ADDR_W - 1
) (
    input  logic              clk_k,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              rd_wn,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d_in,
    input  logic [LANES-1:0]  bw_n,
    output logic              rd_go,
    output logic [PAIR_W-1:0] rd_pair,
    output logic              rd_start,
    output logic              wr_go,
    output logic [PAIR_W-1:0] wr_pair,
    output logic              wr_start,
    output logic [DATA_W-1:0] wr_data0,
    output logic [LANES-1:0]  wr_en0
);
    localparam logic SEED_FROM_ADDR = (START_ZERO == 0);

    cmd_e              cap_q, cap_d;
    cmd_e              iss_q, iss_d;
    logic [PAIR_W-1:0] cap_pair_q, iss_pair_q;
    logic              cap_start_q, iss_start_q;
    logic [DATA_W-1:0] beat0_data_q;
    logic [LANES-1:0]  beat0_en_q;
    logic              seed;

    assign seed = addr[0] & SEED_FROM_ADDR;

    // next-state logic of both pipeline stages
    always_comb begin
        cap_d = CMD_IDLE;
        if (!load_n) begin
            cap_d = rd_wn ? CMD_READ : CMD_WRITE;
        end
        unique case (cap_q)
            CMD_READ:  iss_d = CMD_READ;
            CMD_WRITE: iss_d = CMD_WRITE;
            default:   iss_d = CMD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= CMD_IDLE;
            iss_q <= CMD_IDLE;
        end else begin
            cap_q <= cap_d;
            iss_q <= iss_d;
        end
    end

    // datapath registers carried along with the command
    always_ff @(posedge clk_k) begin
        if (!load_n) begin
            cap_pair_q  <= addr[ADDR_W-1:1];
            cap_start_q <= seed;
        end
        iss_pair_q  <= cap_pair_q;
        iss_start_q <= cap_start_q;
        if (cap_q == CMD_WRITE) begin
            beat0_data_q <= d_in;
            beat0_en_q   <= ~bw_n;
        end
    end

    // outputs decoded from the issue stage
    always_comb begin
        rd_go = 1'b0;
        wr_go = 1'b0;
        unique case (iss_q)
            CMD_READ:  rd_go = 1'b1;
            CMD_WRITE: wr_go = 1'b1;
            default: begin
                rd_go = 1'b0;
                wr_go = 1'b0;
            end
        endcase
    end

    assign rd_pair  = iss_pair_q;
    assign rd_start = iss_start_q;
    assign wr_pair  = iss_pair_q;
    assign wr_start = iss_start_q;
    assign wr_data0 = beat0_data_q;
    assign wr_en0   = beat0_en_q;

    AST_UNLOADED_STAYS_IDLE: assert property (@(posedge clk_k) disable iff (!rst_n)
        load_n |=> (cap_q == CMD_IDLE)); // R1
    AST_READ_SELECT: assert property (@(posedge clk_k) disable iff (!rst_n)
        (!load_n && rd_wn) |=> (cap_q == CMD_READ)); // R2
    AST_WRITE_ISSUES: assert property (@(posedge clk_k) disable iff (!rst_n)
        (cap_q == CMD_WRITE) |=> wr_go); // R5
    AST_READ_ISSUES: assert property (@(posedge clk_k) disable iff (!rst_n)
        (cap_q == CMD_READ) |=> (rd_go && !wr_go)); // R7
endmodule

// File: rtl/ddrb_array.sv
`timescale 1ns/1ps
module ddrb_array #(
    parameter int ADDR_W  = 4,
    parameter int LANE_W  = 9,
    parameter int LANES   = 2,
    localparam int DATA_W = LANE_W * LANES,
    localparam int PAIR_W = ADDR_W - 1,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk_kn,
    input  logic              wr_go,
    input  logic [PAIR_W-1:0] wr_pair,
    input  logic              wr_start,
    input  logic [DATA_W-1:0] wr_data0,
    input  logic [LANES-1:0]  wr_en0,
    input  logic [DATA_W-1:0] wr_data1,
    input  logic [LANES-1:0]  wr_en1,
    input  logic [ADDR_W-1:0] rd_idx0,
    input  logic [ADDR_W-1:0] rd_idx1,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1
);
    logic [ADDR_W-1:0] widx0, widx1;

    assign widx0 = {wr_pair, wr_start};
    assign widx1 = {wr_pair, ~wr_start};

    // one bank per lane; both beats commit together on the K# edge
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk_kn) begin
            if (wr_go && wr_en0[l]) begin
                bank[widx0] <= wr_data0[l*LANE_W +: LANE_W];
            end
            if (wr_go && wr_en1[l]) begin
                bank[widx1] <= wr_data1[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data0[l*LANE_W +: LANE_W] = bank[rd_idx0];
        assign rd_data1[l*LANE_W +: LANE_W] = bank[rd_idx1];
    end
endmodule

// File: rtl/ddrb_rd_out.sv
`timescale 1ns/1ps
module ddrb_rd_out
    import ddrb_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 18,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              oclk_p,
    input  logic              oclk_n,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [PAIR_W-1:0] rd_pair,
    input  logic              rd_start,
    input  logic [DATA_W-1:0] rd_data0,
    input  logic [DATA_W-1:0] rd_data1,
    output logic [ADDR_W-1:0] rd_idx0,
    output logic [ADDR_W-1:0] rd_idx1,
    output logic [DATA_W-1:0] q_out,
    output logic              q_oe
);
    ostate_e           lead_q, lead_d;
    ostate_e           trail_q, trail_d;
    logic [PAIR_W-1:0] hold_pair_q;
    logic              hold_start_q;
    logic [DATA_W-1:0] lead_data_q, trail_data_q;

    // next-state logic for the two phase registers
    always_comb begin
        lead_d = rd_go ? OS_LEAD : OS_QUIET;
        unique case (lead_q)
            OS_LEAD: trail_d = OS_TRAIL;
            default: trail_d = OS_QUIET;
        endcase
    end

    // state registers, one per output phase
    always_ff @(posedge oclk_n or negedge rst_n) begin
        if (!rst_n) begin
            lead_q <= OS_QUIET;
        end else begin
            lead_q <= lead_d;
        end
    end

    always_ff @(posedge oclk_p or negedge rst_n) begin
        if (!rst_n) begin
            trail_q <= OS_QUIET;
        end else begin
            trail_q <= trail_d;
        end
    end

    // beat registers
    always_ff @(posedge oclk_n) begin
        if (rd_go) begin
            lead_data_q  <= rd_data0;
            hold_pair_q  <= rd_pair;
            hold_start_q <= rd_start;
        end
    end

    always_ff @(posedge oclk_p) begin
        if (lead_q == OS_LEAD) begin
            trail_data_q <= rd_data1;
        end
    end

    assign rd_idx0 = {rd_pair, rd_start};
    assign rd_idx1 = {hold_pair_q, ~hold_start_q};

    // output mux: the positive phase shows the trailing beat
    always_comb begin
        if (oclk_p) begin
            q_out = trail_data_q;
            q_oe  = (trail_q == OS_TRAIL);
        end else begin
            q_out = lead_data_q;
            q_oe  = (lead_q == OS_LEAD);
        end
    end

    AST_TRAIL_AFTER_LEAD: assert property (@(posedge oclk_p) disable iff (!rst_n)
        (lead_q == OS_LEAD) |=> (trail_q == OS_TRAIL)); // R3
    AST_LEAD_ON_READ: assert property (@(posedge oclk_n) disable iff (!rst_n)
        rd_go |=> (lead_q == OS_LEAD)); // R7
    AST_QUIET_WITHOUT_READ: assert property (@(posedge oclk_n) disable iff (!rst_n)
        !rd_go |=> (lead_q == OS_QUIET)); // R9
endmodule

// File: rtl/ddrb_sram_port.sv
`timescale 1ns/1ps
module ddrb_sram_port #(
    parameter int ADDR_W     = 4,
    parameter int LANE_W     = 9,
    parameter int LANES      = 2,
    parameter int START_ZERO = 0,
    localparam int DATA_W    = LANE_W * LANES,
    localparam int PAIR_W    = ADDR_W - 1
) (
    input  logic              clk_k,
    input  logic              clk_kn,
    input  logic              clk_c,
    input  logic              clk_cn,
    input  logic              single_clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              rd_wn,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q_out,
    output logic              q_oe,
    output logic              echo_p,
    output logic              echo_n
);
    logic              oclk_p, oclk_n;
    logic              rd_go, wr_go;
    logic [PAIR_W-1:0] rd_pair, wr_pair;
    logic              rd_start, wr_start;
    logic [DATA_W-1:0] wr_data0, rd_data0, rd_data1;
    logic [LANES-1:0]  wr_en0, wr_en1;
    logic [ADDR_W-1:0] rd_idx0, rd_idx1;

    assign oclk_p = single_clk ? clk_k  : clk_c;
    assign oclk_n = single_clk ? clk_kn : clk_cn;
    assign echo_p = oclk_p;
    assign echo_n = oclk_n;
    assign wr_en1 = ~bw_n;

    ddrb_cmd_decode #(
        .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .START_ZERO(START_ZERO)
    ) u_cmd (
        .clk_k(clk_k), .rst_n(rst_n), .load_n(load_n), .rd_wn(rd_wn),
        .addr(addr), .d_in(d_in), .bw_n(bw_n),
        .rd_go(rd_go), .rd_pair(rd_pair), .rd_start(rd_start),
        .wr_go(wr_go), .wr_pair(wr_pair), .wr_start(wr_start),
        .wr_data0(wr_data0), .wr_en0(wr_en0)
    );

    ddrb_array #(
        .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
    ) u_array (
        .clk_kn(clk_kn), .wr_go(wr_go), .wr_pair(wr_pair), .wr_start(wr_start),
        .wr_data0(wr_data0), .wr_en0(wr_en0), .wr_data1(d_in), .wr_en1(wr_en1),
        .rd_idx0(rd_idx0), .rd_idx1(rd_idx1),
        .rd_data0(rd_data0), .rd_data1(rd_data1)
    );

    ddrb_rd_out #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_out (
        .oclk_p(oclk_p), .oclk_n(oclk_n), .rst_n(rst_n),
        .rd_go(rd_go), .rd_pair(rd_pair), .rd_start(rd_start),
        .rd_data0(rd_data0), .rd_data1(rd_data1),
        .rd_idx0(rd_idx0), .rd_idx1(rd_idx1),
        .q_out(q_out), .q_oe(q_oe)
    );
endmodule

// File: tb/ddrb_sram_port_bench.sv
`timescale 1ns/100ps
module ddrb_sram_port_bench;
    localparam int AW = 4;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int DW = LW * NL;
    localparam int DEPTH = 1 << AW;

    logic clk_k = 1'b0;
    logic c_raw = 1'b0;
    logic c_run = 1'b1;
    logic single_clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_n = 1'b1;
    logic rd_wn = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bw_n = '1;
    logic [DW-1:0] d_in = '0;
    logic clk_kn, clk_c, clk_cn;
    logic [DW-1:0] q_a, q_z;
    logic oe_a, oe_z, ep_a, en_a, ep_z, en_z;

    assign clk_kn = ~clk_k;
    assign clk_c  = c_run & c_raw;
    assign clk_cn = c_run & ~c_raw;

    always #4 clk_k = ~clk_k;
    always @(clk_k) c_raw <= #1 clk_k;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] ref_a [DEPTH];
    logic [DW-1:0] ref_z [DEPTH];

    ddrb_sram_port #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .START_ZERO(0)) u_ddrb_sram_port (
        .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_c), .clk_cn(clk_cn),
        .single_clk(single_clk), .rst_n(rst_n), .load_n(load_n), .rd_wn(rd_wn),
        .addr(addr), .bw_n(bw_n), .d_in(d_in),
        .q_out(q_a), .q_oe(oe_a), .echo_p(ep_a), .echo_n(en_a));

    ddrb_sram_port #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .START_ZERO(1)) u_ddrb_sram_port_z (
        .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_c), .clk_cn(clk_cn),
        .single_clk(single_clk), .rst_n(rst_n), .load_n(load_n), .rd_wn(rd_wn),
        .addr(addr), .bw_n(bw_n), .d_in(d_in),
        .q_out(q_z), .q_oe(oe_z), .echo_p(ep_z), .echo_n(en_z));

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic int widx(input logic [AW-1:0] a, input bit beat, input bit zero);
        bit s;
        s = zero ? 1'b0 : a[0];
        return int'({a[AW-1:1], beat ? ~s : s});
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [NL-1:0] m);
        logic [DW-1:0] r;
        r = old;
        for (int l = 0; l < NL; l++) begin
            if (!m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
        end
        return r;
    endfunction

    task automatic ref_write(input logic [AW-1:0] a, input logic [DW-1:0] w0, input logic [NL-1:0] m0,
                             input logic [DW-1:0] w1, input logic [NL-1:0] m1);
        ref_a[widx(a, 0, 0)] = merge(ref_a[widx(a, 0, 0)], w0, m0);
        ref_a[widx(a, 1, 0)] = merge(ref_a[widx(a, 1, 0)], w1, m1);
        ref_z[widx(a, 0, 1)] = merge(ref_z[widx(a, 0, 1)], w0, m0);
        ref_z[widx(a, 1, 1)] = merge(ref_z[widx(a, 1, 1)], w1, m1);
    endtask

    // R2 R5 R6: write command, then beat 0 on K, beat 1 on K#
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] w0, input logic [NL-1:0] m0,
                            input logic [DW-1:0] w1, input logic [NL-1:0] m1);
        @(posedge clk_k); #2 load_n = 1'b0; rd_wn = 1'b0; addr = a;
        @(posedge clk_k); #2 load_n = 1'b1; rd_wn = 1'b1; d_in = w0; bw_n = m0;
        @(posedge clk_k); #2 d_in = w1; bw_n = m1;
        #4 d_in = '0; bw_n = '1;
        ref_write(a, w0, m0, w1, m1);
    endtask

    // R3 R4 R7 R9: read with both beats and the enable window checked
    task automatic do_read(input logic [AW-1:0] a, input string tag);
        @(posedge clk_k); #2 load_n = 1'b0; rd_wn = 1'b1; addr = a;
        @(posedge clk_k); #2 load_n = 1'b1;
        #9 check(DW'(oe_a), DW'(1'b0), {"R9 quiet before beat0 ", tag});
        #4 check(q_a, ref_a[widx(a, 0, 0)], {"R4 R7 beat0 ", tag});
        check(q_z, ref_z[widx(a, 0, 1)], {"R4 R7 beat0 zero-start ", tag});
        check(DW'(oe_a), DW'(1'b1), {"R3 oe beat0 ", tag});
        #4 check(q_a, ref_a[widx(a, 1, 0)], {"R4 R7 beat1 ", tag});
        check(q_z, ref_z[widx(a, 1, 1)], {"R4 R7 beat1 zero-start ", tag});
        check(DW'(oe_z), DW'(1'b1), {"R3 oe beat1 ", tag});
        #4 check(DW'(oe_a), DW'(1'b0), {"R3 R9 oe after burst ", tag});
    endtask

    // R1: an unloaded edge with write direction and live data changes nothing
    task automatic unloaded_edges(input logic [AW-1:0] a);
        @(posedge clk_k); #2 load_n = 1'b1; rd_wn = 1'b0; addr = a; d_in = 18'h3FFFF; bw_n = '0;
        repeat (3) @(posedge clk_k);
        #3 check(DW'(oe_a), DW'(1'b0), "R1 no enable on unloaded edge, high phase");
        #4 check(DW'(oe_a), DW'(1'b0), "R1 no enable on unloaded edge, low phase");
        rd_wn = 1'b1; d_in = '0; bw_n = '1;
        do_read(a, "R1 unchanged after unloaded edges");
    endtask

    // R11: read issued on the edge right after a write to the same address
    task automatic write_then_read(input logic [AW-1:0] a, input logic [DW-1:0] w0, input logic [NL-1:0] m0,
                                   input logic [DW-1:0] w1, input logic [NL-1:0] m1);
        @(posedge clk_k); #2 load_n = 1'b0; rd_wn = 1'b0; addr = a;
        @(posedge clk_k); #2 rd_wn = 1'b1; d_in = w0; bw_n = m0;
        @(posedge clk_k); #2 load_n = 1'b1; d_in = w1; bw_n = m1;
        ref_write(a, w0, m0, w1, m1);
        #4 d_in = '0; bw_n = '1;
        #9 check(q_a, ref_a[widx(a, 0, 0)], "R11 read-after-write beat0");
        check(q_z, ref_z[widx(a, 0, 1)], "R11 read-after-write beat0 zero-start");
        #4 check(q_a, ref_a[widx(a, 1, 0)], "R11 read-after-write beat1");
        #4 check(DW'(oe_a), DW'(1'b0), "R11 R3 enable drops after burst");
    endtask

    // R11: reads on consecutive K edges stream four beats
    task automatic two_reads(input logic [AW-1:0] a, input logic [AW-1:0] b);
        @(posedge clk_k); #2 load_n = 1'b0; rd_wn = 1'b1; addr = a;
        @(posedge clk_k); #2 addr = b;
        @(posedge clk_k); #2 load_n = 1'b1;
        #5 check(q_a, ref_a[widx(a, 0, 0)], "R11 back-to-back first beat0");
        #4 check(q_a, ref_a[widx(a, 1, 0)], "R11 back-to-back first beat1");
        #4 check(q_a, ref_a[widx(b, 0, 0)], "R11 back-to-back second beat0");
        check(DW'(oe_a), DW'(1'b1), "R11 enable held between bursts");
        #4 check(q_a, ref_a[widx(b, 1, 0)], "R11 back-to-back second beat1");
        check(q_z, ref_z[widx(b, 1, 1)], "R11 back-to-back second beat1 zero-start");
        #4 check(DW'(oe_a), DW'(1'b0), "R3 enable drops after second burst");
    endtask

    // R8: just after the K# edge the enable is up only in single-clock mode
    task automatic mode_probe(input bit single);
        @(posedge clk_k); #2 load_n = 1'b0; rd_wn = 1'b1; addr = 4'd3;
        @(posedge clk_k); #2 load_n = 1'b1;
        #10.5 check(DW'(oe_a), DW'(single), "R8 beat0 timing source");
        #0.5;
        #9;
    endtask

    // R10: echo clocks follow the selected pair
    task automatic echo_probe(input bit single);
        @(posedge clk_k); #0.5;
        check(DW'(ep_a), DW'(single), "R10 echo_p just after K rise");
        check(DW'(en_a), DW'(!single), "R10 echo_n just after K rise");
        #4 check(DW'(ep_a), DW'(!single), "R10 echo_p just after K# rise");
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk_k);
        #3 check(DW'(oe_a), DW'(1'b0), "R9 enable low in reset");
        check(DW'(oe_z), DW'(1'b0), "R9 enable low in reset zero-start");
        @(posedge clk_k); #2 rst_n = 1'b1;

        // fill every word with a full-mask burst
        for (int p = 0; p < DEPTH / 2; p++) begin
            do_write(AW'(2 * p), DW'(18'h01000 + 17 * p), '0, DW'(18'h20000 + 33 * p), '0);
        end

        // R2 R4: even and odd start addresses, both orders on both instances
        do_write(4'd6, 18'h1A5A5, 2'b00, 18'h05A5A, 2'b00);
        do_read(4'd6, "even start");
        do_read(4'd7, "odd start same pair");
        do_write(4'd9, 18'h2CAFE, 2'b00, 18'h01234, 2'b00);
        do_read(4'd9, "odd start write");
        do_read(4'd8, "even read of odd write");

        // R6: lane masks per beat
        do_write(4'd4, 18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01);
        do_read(4'd4, "R6 lane masks");
        do_write(4'd4, 18'h00000, 2'b11, 18'h00000, 2'b11);
        do_read(4'd4, "R6 all lanes masked");

        // R1
        unloaded_edges(4'd2);

        // R11
        write_then_read(4'd11, 18'h15555, 2'b00, 18'h2AAAA, 2'b01);
        two_reads(4'd0, 4'd13);

        // R8 R10 in output-clock mode
        mode_probe(1'b0);
        echo_probe(1'b0);

        // R8 R10 in single-clock mode with the output pair stopped
        @(posedge clk_k); #2 single_clk = 1'b1; c_run = 1'b0;
        mode_probe(1'b1);
        echo_probe(1'b1);
        do_read(4'd5, "single-clock mode");
        write_then_read(4'd14, 18'h0F0F0, 2'b00, 18'h30303, 2'b10);
        @(posedge clk_k); #2 single_clk = 1'b0; c_run = 1'b1;
        do_read(4'd14, "back in output-clock mode");

        repeat (2) @(posedge clk_k);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule